// File: doc/BRIEF.md
# I/O Request Legality Checker

This block judges each incoming logical-layer I/O request once an upstream parser has pulled out its header fields. Those fields are the transaction type, priority, size code, word pointer, address, payload presence, payload byte count and a too-short indication. The block applies the protocol's decode rules to them and returns a registered verdict: legal or illegal. For an illegal request it also says whether the requester is owed an ERROR response packet.

A second source of error responses comes from the memory-mapped read side. When a read transfer ends with its error input raised on the last beat, the block asks for an ERROR response for that read.

The block also keeps a saturating count of illegal requests. Up to four mapping windows are configured through static inputs. Each window has an enable bit, a base and a mask.

The control is a three-state machine:

- ST_IDLE presents nothing.
- ST_VERDICT presents a packet verdict.
- ST_RDERR presents a read-completion error response.

Every state follows the same transition rule:

- go to ST_VERDICT after any cycle with a packet strobe;
- otherwise go to ST_RDERR when a read error arrives or is pending;
- otherwise go to ST_IDLE.

A read error that collides with a packet strobe is held in a pending flag. It is reported in the first later cycle that has no strobe.

Top module: `io_req_legality_chk`

## Requirements
- R1: A request of any type whose 2-bit priority equals 3 is illegal.
- R2: A request flagged as too short by the parser (`pkt_short`=1) is illegal regardless of its other fields.
- R3: Type encodings are NREAD=0, NWRITE=1, NWRITE_R=2, SWRITE=3, ATOMIC=4, and 5..7 are other types. NWRITE or NWRITE_R without payload is illegal, and NREAD with payload is illegal.
- R4: For NWRITE/NWRITE_R, the size/pointer pair is reserved, and so illegal, when size ≥ 13; when size is 8..12 with pointer 1; and when size is 4..7 with pointer 1.
- R5: For NWRITE/NWRITE_R carrying payload, the payload byte count must equal the encoded length: size+1 for size 0..7, and 8 << (size−8) for size 8..12. Any other count is illegal.
- R6: An NREAD is illegal unless its size code is 7 (one full 8-byte beat) or 8..12 (whole beats). The pointer is ignored for reads.
- R7: NREAD, NWRITE, NWRITE_R and SWRITE must hit an enabled window, where a hit means (addr & mask) == (base & mask). Disabled windows never hit. ATOMIC and other types skip this check.
- R8: `chk_valid` is 1 exactly in the cycle after a `pkt_valid` cycle, carrying `chk_legal` for that packet. Otherwise `chk_valid` and `chk_legal` are 0.
- R9: During a verdict, `err_rsp` is 1 only when the packet is illegal and its type is NREAD, NWRITE_R or ATOMIC.
- R10: A cycle with `rd_last` and `rd_err` both 1 gives one cycle of `err_rsp`=`err_rsp_rd`=1 with `chk_valid`=0 in the next cycle without `pkt_valid`. `rd_err` without `rd_last`, or `rd_last` without `rd_err`, has no effect.
- R11: `err_cnt` rises by one with each illegal verdict, becoming visible together with that verdict. It saturates at 2^CNT_W−1, and read errors do not change it.
- R12: After reset, `chk_valid`, `chk_legal`, `err_rsp`, `err_rsp_rd` and `err_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Request fields are valid this cycle |
| pkt_ttype | input | 3 | Transaction type code |
| pkt_prio | input | 2 | Request priority |
| pkt_size | input | 4 | Read or write size code |
| pkt_wdptr | input | 1 | Word pointer |
| pkt_addr | input | ADDR_W | Request address |
| pkt_has_pl | input | 1 | Request carries payload |
| pkt_len | input | LEN_W | Payload byte count |
| pkt_short | input | 1 | Parser found the packet too short |
| win_en | input | NWIN | Window enables |
| win_base | input | NWIN*ADDR_W | Window bases, window 0 in the low bits |
| win_mask | input | NWIN*ADDR_W | Window masks, window 0 in the low bits |
| rd_last | input | 1 | Final beat of a memory-mapped read |
| rd_err | input | 1 | Read error indication |
| chk_valid | output | 1 | Verdict presented |
| chk_legal | output | 1 | Request was legal |
| err_rsp | output | 1 | ERROR response owed |
| err_rsp_rd | output | 1 | Owed response stems from a read error |
| err_cnt | output | CNT_W | Saturating illegal-request count |

## Verification
Directed packets each break exactly one rule against an otherwise legal baseline:

- a priority of 3;
- the too-short flag;
- wrong payload presence;
- each class of reserved size/pointer pair;
- an off-by-one payload length;
- an address in a disabled window or in no window.

This pins down each rule on its own. The same faults are applied to NWRITE and to NWRITE_R, which tells the response decision apart from the verdict.

Seeded random requests then mix several faults at once. They catch rules that mask or duplicate each other.

Timed read errors cover three cases: alone, with only one of the two read inputs raised, and colliding with a packet strobe. Together they separate immediate, suppressed and deferred responses. A run of more than fifteen illegal packets reaches counter saturation.

// File: rtl/io_req_pkg.sv
package io_req_pkg;

    typedef enum logic [2:0] {
        TT_NREAD    = 3'd0,
        TT_NWRITE   = 3'd1,
        TT_NWRITE_R = 3'd2,
        TT_SWRITE   = 3'd3,
        TT_ATOMIC   = 3'd4,
        TT_OTHER5   = 3'd5,
        TT_OTHER6   = 3'd6,
        TT_OTHER7   = 3'd7
    } ttype_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_VERDICT = 2'd1,
        ST_RDERR   = 2'd2
    } chk_state_e;

    localparam logic [1:0] PRIO_BANNED  = 2'd3;
    localparam logic [3:0] SZ_HALF_LO   = 4'd4;
    localparam logic [3:0] SZ_FULL_BEAT = 4'd7;
    localparam logic [3:0] SZ_BLK_FIRST = 4'd8;
    localparam logic [3:0] SZ_BLK_LAST  = 4'd12;
    localparam int         BEAT_BYTES   = 8;

endpackage

// File: rtl/io_req_size_dec.sv
module io_req_size_dec
    import io_req_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic [3:0]       size_code,
    input  logic             wdptr,
    output logic [LEN_W-1:0] len_bytes,
    output logic             wr_reserved,
    output logic             rd_whole
);

    always_comb begin
        len_bytes   = '0;
        wr_reserved = 1'b0;
        rd_whole    = 1'b0;
        if (size_code <= SZ_FULL_BEAT) begin
            // partial or single beat: byte count is code plus one
            len_bytes   = LEN_W'(size_code) + LEN_W'(1);
            wr_reserved = wdptr && (size_code >= SZ_HALF_LO);
            rd_whole    = (size_code == SZ_FULL_BEAT);
        end else if (size_code <= SZ_BLK_LAST) begin
            // multi-beat block, doubling per code step
            len_bytes   = LEN_W'(BEAT_BYTES) << (size_code - SZ_BLK_FIRST);
            wr_reserved = wdptr;
            rd_whole    = 1'b1;
        end else begin
            wr_reserved = 1'b1;
        end
    end

endmodule

// File: rtl/io_req_win_match.sv
module io_req_win_match #(
    parameter int ADDR_W = 32,
    parameter int NWIN   = 4
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NWIN-1:0]        win_en,
    input  logic [NWIN*ADDR_W-1:0] win_base,
    input  logic [NWIN*ADDR_W-1:0] win_mask,
    output logic                   any_hit
);

    logic [NWIN-1:0] hit_vec;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        logic [ADDR_W-1:0] base_g;
        logic [ADDR_W-1:0] mask_g;
        assign base_g     = win_base[g*ADDR_W +: ADDR_W];
        assign mask_g     = win_mask[g*ADDR_W +: ADDR_W];
        assign hit_vec[g] = win_en[g] && ((addr & mask_g) == (base_g & mask_g));
    end

    assign any_hit = |hit_vec;

endmodule

// File: rtl/io_req_rules.sv
module io_req_rules
    import io_req_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic [2:0]       ttype,
    input  logic [1:0]       prio,
    input  logic [3:0]       size_code,
    input  logic             wdptr,
    input  logic             has_pl,
    input  logic [LEN_W-1:0] pl_len,
    input  logic             too_short,
    input  logic             win_hit,
    output logic             legal,
    output logic             rsp_owed
);

    logic [LEN_W-1:0] exp_len;
    logic             wr_rsvd;
    logic             rd_whole;
    logic             bad;
    ttype_e           tt;

    io_req_size_dec #(.LEN_W(LEN_W)) u_size (
        .size_code   (size_code),
        .wdptr       (wdptr),
        .len_bytes   (exp_len),
        .wr_reserved (wr_rsvd),
        .rd_whole    (rd_whole)
    );

    assign tt = ttype_e'(ttype);

    always_comb begin
        bad = (prio == PRIO_BANNED) || too_short;
        case (tt)
            TT_NREAD: begin
                if (has_pl || !rd_whole || !win_hit) bad = 1'b1;
            end
            TT_NWRITE, TT_NWRITE_R: begin
                if (!has_pl || wr_rsvd || !win_hit) bad = 1'b1;
                if (has_pl && (pl_len != exp_len))  bad = 1'b1;
            end
            TT_SWRITE: begin
                if (!win_hit) bad = 1'b1;
            end
            default: ;
        endcase
    end

    assign legal    = !bad;
    assign rsp_owed = bad && ((tt == TT_NREAD) || (tt == TT_NWRITE_R) || (tt == TT_ATOMIC));

endmodule

// File: rtl/io_req_legality_chk.sv
module io_req_legality_chk
    import io_req_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NWIN   = 4,
    parameter int LEN_W  = 9,
    parameter int CNT_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pkt_valid,
    input  logic [2:0]             pkt_ttype,
    input  logic [1:0]             pkt_prio,
    input  logic [3:0]             pkt_size,
    input  logic                   pkt_wdptr,
    input  logic [ADDR_W-1:0]      pkt_addr,
    input  logic                   pkt_has_pl,
    input  logic [LEN_W-1:0]       pkt_len,
    input  logic                   pkt_short,
    input  logic [NWIN-1:0]        win_en,
    input  logic [NWIN*ADDR_W-1:0] win_base,
    input  logic [NWIN*ADDR_W-1:0] win_mask,
    input  logic                   rd_last,
    input  logic                   rd_err,
    output logic                   chk_valid,
    output logic                   chk_legal,
    output logic                   err_rsp,
    output logic                   err_rsp_rd,
    output logic [CNT_W-1:0]       err_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    chk_state_e       state_q, state_d;
    logic             win_hit;
    logic             legal_w, owed_w;
    logic             legal_q, owed_q;
    logic             pend_q, pend_d;
    logic             rd_event;
    logic [CNT_W-1:0] cnt_q;

    io_req_win_match #(.ADDR_W(ADDR_W), .NWIN(NWIN)) u_win (
        .addr     (pkt_addr),
        .win_en   (win_en),
        .win_base (win_base),
        .win_mask (win_mask),
        .any_hit  (win_hit)
    );

    io_req_rules #(.LEN_W(LEN_W)) u_rules (
        .ttype     (pkt_ttype),
        .prio      (pkt_prio),
        .size_code (pkt_size),
        .wdptr     (pkt_wdptr),
        .has_pl    (pkt_has_pl),
        .pl_len    (pkt_len),
        .too_short (pkt_short),
        .win_hit   (win_hit),
        .legal     (legal_w),
        .rsp_owed  (owed_w)
    );

    assign rd_event = rd_last && rd_err;

    // next state and deferral of a read error that meets a packet strobe
    always_comb begin
        pend_d = pkt_valid ? (pend_q || rd_event) : 1'b0;
        unique case (state_q)
            ST_IDLE, ST_VERDICT, ST_RDERR: begin
                if (pkt_valid)                state_d = ST_VERDICT;
                else if (rd_event || pend_q)  state_d = ST_RDERR;
                else                          state_d = ST_IDLE;
            end
            default:                          state_d = ST_IDLE;
        endcase
    end

    // state register with the per-packet result and saturating count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            legal_q <= 1'b0;
            owed_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            if (pkt_valid) begin
                legal_q <= legal_w;
                owed_q  <= owed_w;
                if (!legal_w && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        chk_valid  = 1'b0;
        chk_legal  = 1'b0;
        err_rsp    = 1'b0;
        err_rsp_rd = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_VERDICT: begin
                chk_valid = 1'b1;
                chk_legal = legal_q;
                err_rsp   = owed_q;
            end
            ST_RDERR: begin
                err_rsp    = 1'b1;
                err_rsp_rd = 1'b1;
            end
            default: ;
        endcase
    end

    assign err_cnt = cnt_q;

endmodule

// File: rtl/io_req_legality_chk_sva.sv
module io_req_legality_chk_sva
    import io_req_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic [2:0]       pkt_ttype,
    input logic [1:0]       pkt_prio,
    input logic             pkt_has_pl,
    input logic             pkt_short,
    input logic             chk_valid,
    input logic             chk_legal,
    input logic             err_rsp,
    input logic             err_rsp_rd,
    input logic [CNT_W-1:0] err_cnt
);

    // R1
    prio_ban_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_prio == PRIO_BANNED) |=> (chk_valid && !chk_legal));

    // R2
    short_ban_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_short) |=> !chk_legal);

    // R3
    read_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ttype == 3'd0 && pkt_has_pl) |=> !chk_legal);

    // R8
    verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> chk_valid);

    // R8
    verdict_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> $past(pkt_valid));

    // R9
    rsp_needs_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && err_rsp) |-> !chk_legal);

    // R10
    rd_rsp_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_rsp_rd |-> (err_rsp && !chk_valid));

    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + CNT_W'(1) && chk_valid && !chk_legal));

endmodule

bind io_req_legality_chk io_req_legality_chk_sva #(.CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_valid  (pkt_valid),
    .pkt_ttype  (pkt_ttype),
    .pkt_prio   (pkt_prio),
    .pkt_has_pl (pkt_has_pl),
    .pkt_short  (pkt_short),
    .chk_valid  (chk_valid),
    .chk_legal  (chk_legal),
    .err_rsp    (err_rsp),
    .err_rsp_rd (err_rsp_rd),
    .err_cnt    (err_cnt)
);

// File: tb/io_req_legality_chk_bench.sv
`timescale 1ns/1ps
module io_req_legality_chk_bench;

    localparam int ADDR_W = 32;
    localparam int NWIN   = 4;
    localparam int LEN_W  = 9;
    localparam int CNT_W  = 4;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   pkt_valid, pkt_wdptr, pkt_has_pl, pkt_short;
    logic [2:0]             pkt_ttype;
    logic [1:0]             pkt_prio;
    logic [3:0]             pkt_size;
    logic [ADDR_W-1:0]      pkt_addr;
    logic [LEN_W-1:0]       pkt_len;
    logic [NWIN-1:0]        win_en;
    logic [NWIN*ADDR_W-1:0] win_base, win_mask;
    logic                   rd_last, rd_err;
    logic                   chk_valid, chk_legal, err_rsp, err_rsp_rd;
    logic [CNT_W-1:0]       err_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    int model_cnt = 0;

    always #4 clk = ~clk;

    io_req_legality_chk #(.ADDR_W(ADDR_W), .NWIN(NWIN), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_io_req_legality_chk (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ttype(pkt_ttype),
        .pkt_prio(pkt_prio), .pkt_size(pkt_size), .pkt_wdptr(pkt_wdptr),
        .pkt_addr(pkt_addr), .pkt_has_pl(pkt_has_pl), .pkt_len(pkt_len),
        .pkt_short(pkt_short), .win_en(win_en), .win_base(win_base),
        .win_mask(win_mask), .rd_last(rd_last), .rd_err(rd_err),
        .chk_valid(chk_valid), .chk_legal(chk_legal), .err_rsp(err_rsp),
        .err_rsp_rd(err_rsp_rd), .err_cnt(err_cnt)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int len_of(input logic [3:0] s);
        if (s <= 4'd7)  return int'(s) + 1;
        if (s <= 4'd12) return 8 << (int'(s) - 8);
        return 0;
    endfunction

    function automatic bit wr_rsvd_of(input logic [3:0] s, input logic p);
        return (s >= 4'd13) || (p && s >= 4'd4);
    endfunction

    function automatic bit hit_of(input logic [ADDR_W-1:0] a);
        bit h = 0;
        for (int w = 0; w < NWIN; w++) begin
            logic [ADDR_W-1:0] b = win_base[w*ADDR_W +: ADDR_W];
            logic [ADDR_W-1:0] m = win_mask[w*ADDR_W +: ADDR_W];
            if (win_en[w] && ((a & m) == (b & m))) h = 1;
        end
        return h;
    endfunction

    function automatic bit legal_of(input logic [2:0] t, input logic [1:0] pr, input logic [3:0] s,
                                    input logic p, input logic [ADDR_W-1:0] a, input logic hp,
                                    input logic [LEN_W-1:0] l, input logic sh);
        bit bad = (pr == 2'd3) || sh;                                   // R1 R2
        if (t == 3'd0 && (hp || !(s == 4'd7 || (s >= 4'd8 && s <= 4'd12)))) bad = 1;  // R3 R6
        if (t == 3'd1 || t == 3'd2) begin
            if (!hp || wr_rsvd_of(s, p)) bad = 1;                       // R3 R4
            if (hp && int'(l) != len_of(s)) bad = 1;                    // R5
        end
        if (t <= 3'd3 && !hit_of(a)) bad = 1;                           // R7
        return !bad;
    endfunction

    // drive at a negedge, check one cycle later at the next negedge
    task automatic send(input logic [2:0] t, input logic [1:0] pr, input logic [3:0] s,
                        input logic p, input logic [ADDR_W-1:0] a, input logic hp,
                        input logic [LEN_W-1:0] l, input logic sh, input string tag);
        bit exp_ok = legal_of(t, pr, s, p, a, hp, l, sh);
        bit exp_rsp = !exp_ok && (t == 3'd0 || t == 3'd2 || t == 3'd4);
        pkt_ttype = t; pkt_prio = pr; pkt_size = s; pkt_wdptr = p; pkt_addr = a;
        pkt_has_pl = hp; pkt_len = l; pkt_short = sh; pkt_valid = 1'b1;
        if (!exp_ok && model_cnt < 15) model_cnt++;
        @(negedge clk);
        pkt_valid = 1'b0;
        check(chk_valid == 1'b1, {tag, " R8 valid"}, chk_valid, 1);
        check(chk_legal == exp_ok, {tag, " legal"}, chk_legal, exp_ok);
        check(err_rsp == exp_rsp, {tag, " R9 rsp"}, err_rsp, exp_rsp);
        check(err_rsp_rd == 1'b0, {tag, " R10 rd flag"}, err_rsp_rd, 0);
        check(int'(err_cnt) == model_cnt, {tag, " R11 count"}, err_cnt, model_cnt);
        @(negedge clk);
        check(chk_valid == 1'b0 && chk_legal == 1'b0, {tag, " R8 idle"}, chk_valid, 0);
    endtask

    localparam logic [ADDR_W-1:0] A_W0 = 32'h0000_1234;  // window 0
    localparam logic [ADDR_W-1:0] A_W2 = 32'h2000_0040;  // disabled window only
    localparam logic [ADDR_W-1:0] A_NO = 32'h5000_0000;  // no window

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        win_en   = 4'b1011;
        win_base = {32'h0000_0000, 32'h2000_0000, 32'h8000_0000, 32'h0000_1000};
        win_mask = {32'hFFFF_FFFF, 32'hF000_0000, 32'hF000_0000, 32'hFFFF_F000};
        rst_n = 1'b0; pkt_valid = 0; pkt_ttype = 0; pkt_prio = 0; pkt_size = 0;
        pkt_wdptr = 0; pkt_addr = 0; pkt_has_pl = 0; pkt_len = 0; pkt_short = 0;
        rd_last = 0; rd_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12
        check(!chk_valid && !chk_legal && !err_rsp && !err_rsp_rd && err_cnt == 0, "R12 reset", err_cnt, 0);

        send(3'd1, 2'd0, 4'd9,  1'b0, A_W0, 1, 9'd16, 0, "base NWRITE legal");
        send(3'd0, 2'd0, 4'd7,  1'b0, A_W0, 0, 9'd0,  0, "base NREAD legal");
        send(3'd0, 2'd3, 4'd7,  1'b0, A_W0, 0, 9'd0,  0, "R1 prio3 NREAD");
        send(3'd5, 2'd3, 4'd0,  1'b0, A_NO, 0, 9'd0,  0, "R1 prio3 other");
        send(3'd1, 2'd0, 4'd9,  1'b0, A_W0, 1, 9'd16, 1, "R2 short NWRITE");
        send(3'd1, 2'd0, 4'd9,  1'b0, A_W0, 0, 9'd0,  0, "R3 NWRITE nopl");
        send(3'd2, 2'd0, 4'd9,  1'b0, A_W0, 0, 9'd0,  0, "R3 NWRITE_R nopl");
        send(3'd0, 2'd0, 4'd7,  1'b0, A_W0, 1, 9'd8,  0, "R3 NREAD pl");
        send(3'd2, 2'd0, 4'd13, 1'b0, A_W0, 1, 9'd0,  0, "R4 size13");
        send(3'd2, 2'd0, 4'd8,  1'b1, A_W0, 1, 9'd8,  0, "R4 blk ptr1");
        send(3'd2, 2'd0, 4'd5,  1'b1, A_W0, 1, 9'd6,  0, "R4 half ptr1");
        send(3'd2, 2'd0, 4'd3,  1'b1, A_W0, 1, 9'd4,  0, "R4 size3 ptr1 legal");
        send(3'd2, 2'd0, 4'd12, 1'b0, A_W0, 1, 9'd128,0, "R5 len128 legal");
        send(3'd2, 2'd0, 4'd12, 1'b0, A_W0, 1, 9'd127,0, "R5 len short");
        send(3'd1, 2'd0, 4'd2,  1'b0, A_W0, 1, 9'd4,  0, "R5 len long");
        send(3'd0, 2'd0, 4'd6,  1'b0, A_W0, 0, 9'd0,  0, "R6 rdsize6");
        send(3'd0, 2'd0, 4'd12, 1'b1, A_W0, 0, 9'd0,  0, "R6 rdsize12 legal");
        send(3'd0, 2'd0, 4'd14, 1'b0, A_W0, 0, 9'd0,  0, "R6 rdsize14");
        send(3'd3, 2'd0, 4'd0,  1'b0, A_W2, 1, 9'd8,  0, "R7 SWRITE disabled win");
        send(3'd3, 2'd0, 4'd0,  1'b0, 32'h8123_4560, 1, 9'd8, 0, "R7 SWRITE win1");
        send(3'd0, 2'd0, 4'd7,  1'b0, A_NO, 0, 9'd0,  0, "R7 NREAD miss");
        send(3'd1, 2'd0, 4'd7,  1'b0, 32'h0000_0000, 1, 9'd8, 0, "R7 exact win3");
        send(3'd4, 2'd0, 4'd0,  1'b0, A_NO, 1, 9'd4,  0, "R7 ATOMIC unchecked");
        send(3'd4, 2'd0, 4'd0,  1'b0, A_NO, 1, 9'd4,  1, "R9 ATOMIC short rsp");

        // R10: plain read error
        rd_last = 1; rd_err = 1;
        @(negedge clk); rd_last = 0; rd_err = 0;
        check(err_rsp && err_rsp_rd && !chk_valid, "R10 rd error", {err_rsp, err_rsp_rd}, 3);
        check(int'(err_cnt) == model_cnt, "R11 rd no count", err_cnt, model_cnt);
        @(negedge clk);
        check(!err_rsp && !err_rsp_rd, "R10 single pulse", err_rsp, 0);
        // R10: only one input raised
        rd_last = 1; rd_err = 0;
        @(negedge clk); rd_last = 0; rd_err = 1;
        check(!err_rsp && !err_rsp_rd, "R10 last only", err_rsp, 0);
        @(negedge clk); rd_err = 0;
        check(!err_rsp && !err_rsp_rd, "R10 err only", err_rsp, 0);
        // R10: collision with packet strobe
        pkt_ttype = 3'd0; pkt_prio = 0; pkt_size = 4'd7; pkt_wdptr = 0; pkt_addr = A_W0;
        pkt_has_pl = 0; pkt_len = 0; pkt_short = 0; pkt_valid = 1; rd_last = 1; rd_err = 1;
        @(negedge clk); pkt_valid = 0; rd_last = 0; rd_err = 0;
        check(chk_valid && chk_legal && !err_rsp_rd, "R10 collide verdict", {chk_valid, err_rsp_rd}, 2);
        @(negedge clk);
        check(err_rsp && err_rsp_rd && !chk_valid, "R10 deferred rd", {err_rsp, err_rsp_rd}, 3);
        @(negedge clk);
        check(!err_rsp && !err_rsp_rd, "R10 deferred once", err_rsp, 0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0] t = 3'($urandom_range(0, 7));
            logic [1:0] pr = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
            logic [3:0] s = 4'($urandom_range(0, 15));
            logic p = 1'($urandom_range(0, 3) == 0);
            logic hp = (t == 3'd0) ? ($urandom_range(0, 9) == 0) : ($urandom_range(0, 9) != 0);
            logic [LEN_W-1:0] l = ($urandom_range(0, 3) != 0) ? LEN_W'(len_of(s)) : LEN_W'($urandom_range(0, 200));
            logic sh = ($urandom_range(0, 19) == 0);
            logic [ADDR_W-1:0] a;
            case ($urandom_range(0, 4))
                0: a = 32'h0000_1000 | 32'($urandom_range(0, 4095));
                1: a = 32'h8000_0000 | 32'($urandom);
                2: a = A_W2;
                3: a = 32'h0;
                default: a = 32'($urandom);
            endcase
            send(t, pr, s, p, a, hp, l, sh, "random R1..");
        end

        // R11 saturation
        for (int k = 0; k < 20; k++) send(3'd1, 2'd3, 4'd7, 1'b0, A_W0, 1, 9'd8, 0, "R11 saturate");
        check(err_cnt == 4'hF, "R11 saturated", err_cnt, 15);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule